// File: doc/BRIEF.md
# Unified Translation Lookaside Buffer with Entry Lockdown

This block is a small, fully associative translation cache that holds virtual-to-physical page mappings for a processor core. One shared array of entries serves two lookup ports at once, one for instruction fetch and one for data access. Each port takes a virtual address and, in the same cycle, returns a hit flag, the translated physical address and a two-bit access-permission code. On a miss, an external page walker resolves the mapping and writes the result back through the refill port.

Three page sizes are held side by side: 4 KB small pages, 64 KB large pages and 1 MB sections. Each entry records its own size, and the size decides which address bits take part in the compare. Small and large pages carry four permission fields, one per quarter of the page, and the lookup address picks the field. A programmable lockdown base protects every entry below that index from replacement. Refills rotate round-robin over the entries at or above the base. A maintenance port can invalidate everything, invalidate the entries covering one address, or move the lockdown base.

Top module: `utlb_lockdown`

## Requirements
- R1: After reset every entry is invalid, the lockdown base is 0 and the refill pointer is 0, so both lookup ports miss.
- R2: An entry matches when it is valid and its stored virtual tag equals the lookup address on bits 31:12 for size code 0 (small), bits 31:16 for code 1 (large) or bits 31:20 for code 2 (section). On a hit the physical address is the stored frame on those same upper bits joined with the lookup address below them. On a miss the address and permission outputs are zero.
- R3: The permission is taken from the refill's 8-bit field, where field q occupies bits 2q+1:2q. The quarter q is lookup bits 11:10 for a small page and 15:14 for a large page. A section always uses field 0.
- R4: The instruction and data ports translate independently in the same cycle from the one shared array, and a refill is visible to both from the cycle after it is written.
- R5: When several valid entries match one address, the lowest-numbered entry supplies the result.
- R6: A refill goes into a victim entry. The victim is the lockdown base if the pointer is below the base, and otherwise it is the pointer. The pointer then moves to victim+1, and wraps to the base after the last entry.
- R7: Entries whose index is below the lockdown base are never overwritten by a refill.
- R8: Maintenance code 3 loads the lockdown base and saturates values above 16 to 16. With a base of 16 every refill is discarded.
- R9: Maintenance code 1 clears the valid bit of every entry, locked ones included.
- R10: Maintenance code 2 clears only the entries that match the supplied address under their own page size. Locked entries are included, and all other entries keep translating.
- R11: A refill presented in the same cycle as any nonzero maintenance code is discarded and the pointer does not move.
- R12: A refill carrying size code 3 is discarded and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ilk_va | input | 32 | Instruction-side lookup virtual address |
| ilk_hit | output | 1 | Instruction-side hit |
| ilk_pa | output | 32 | Instruction-side physical address |
| ilk_perm | output | 2 | Instruction-side access permission |
| dlk_va | input | 32 | Data-side lookup virtual address |
| dlk_hit | output | 1 | Data-side hit |
| dlk_pa | output | 32 | Data-side physical address |
| dlk_perm | output | 2 | Data-side access permission |
| fill_valid | input | 1 | Refill request from the page walker |
| fill_va | input | 32 | Refill virtual address (bits 31:12 stored) |
| fill_pa | input | 32 | Refill physical address (bits 31:12 stored) |
| fill_size | input | 2 | Page size: 0 small, 1 large, 2 section, 3 reserved |
| fill_perm | input | 8 | Four 2-bit permission fields, quarter q in bits 2q+1:2q |
| mnt_op | input | 2 | Maintenance: 0 none, 1 invalidate all, 2 invalidate by address, 3 set lockdown base |
| mnt_va | input | 32 | Address for invalidate by address |
| mnt_base | input | 5 | New lockdown base for code 3 |

## Verification
The hardest condition to reach from the ports is a full array in which locked entries sit next to entries that the pointer has lapped several times. Only that state shows whether refills stay out of the protected range and whether the pointer restarts at the base. The stimulus first fills all sixteen entries with distinct pages and then raises the base part-way. It then issues more refills than there are unlocked slots and sweeps lookups over every page ever loaded, so entries that should survive and entries that should be evicted are both seen on the two ports. Duplicate mappings of one address are loaded into different slots to expose the lowest-index rule. A final randomised phase mixes refills, maintenance and lookups against the reference model.

// File: rtl/utlb_pkg.sv
`timescale 1ns/1ps
package utlb_pkg;

    localparam int VA_W     = 32;
    localparam int SMALL_SH = 12;
    localparam int LARGE_SH = 16;
    localparam int SECT_SH  = 20;
    localparam int PG_W     = VA_W - SMALL_SH;
    localparam int AP_W     = 2;
    localparam int QTR      = 4;
    localparam int AP_ALL_W = QTR * AP_W;

    typedef enum logic [1:0] {
        PG_SMALL = 2'd0,
        PG_LARGE = 2'd1,
        PG_SECT  = 2'd2,
        PG_RSVD  = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        MNT_NONE     = 2'd0,
        MNT_INV_ALL  = 2'd1,
        MNT_INV_VA   = 2'd2,
        MNT_SET_LOCK = 2'd3
    } mnt_op_e;

    typedef struct packed {
        logic                valid;
        pg_size_e            size;
        logic [PG_W-1:0]     vtag;
        logic [PG_W-1:0]     ptag;
        logic [AP_ALL_W-1:0] ap;
    } tlb_entry_t;

    // Tag compare for one entry under its own page size.
    function automatic logic entry_hits(input tlb_entry_t e, input logic [VA_W-1:0] va);
        logic m;
        unique case (e.size)
            PG_SMALL: m = (e.vtag == va[VA_W-1:SMALL_SH]);
            PG_LARGE: m = (e.vtag[PG_W-1:LARGE_SH-SMALL_SH] == va[VA_W-1:LARGE_SH]);
            PG_SECT:  m = (e.vtag[PG_W-1:SECT_SH-SMALL_SH] == va[VA_W-1:SECT_SH]);
            default:  m = 1'b0;
        endcase
        return e.valid && m;
    endfunction

endpackage

// File: rtl/utlb_match.sv
`timescale 1ns/1ps
module utlb_match
    import utlb_pkg::*;
(
    input  tlb_entry_t       ent,
    input  logic [VA_W-1:0]  va,
    output logic             match,
    output logic [VA_W-1:0]  pa,
    output logic [AP_W-1:0]  perm
);

    logic [1:0] qsel;

    always_comb begin
        match = entry_hits(ent, va);
        pa    = '0;
        qsel  = '0;
        unique case (ent.size)
            PG_SMALL: begin
                pa   = {ent.ptag, va[SMALL_SH-1:0]};
                qsel = va[SMALL_SH-1:SMALL_SH-2];
            end
            PG_LARGE: begin
                pa   = {ent.ptag[PG_W-1:LARGE_SH-SMALL_SH], va[LARGE_SH-1:0]};
                qsel = va[LARGE_SH-1:LARGE_SH-2];
            end
            PG_SECT: begin
                pa   = {ent.ptag[PG_W-1:SECT_SH-SMALL_SH], va[SECT_SH-1:0]};
                qsel = 2'd0;
            end
            default: begin
                pa   = '0;
                qsel = 2'd0;
            end
        endcase
        perm = ent.ap[int'(qsel)*AP_W +: AP_W];
    end

endmodule

// File: rtl/utlb_lookup.sv
`timescale 1ns/1ps
module utlb_lookup
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  tlb_entry_t [ENTRIES-1:0]  ents,
    input  logic [VA_W-1:0]           va,
    output logic                      hit,
    output logic [VA_W-1:0]           pa,
    output logic [AP_W-1:0]           perm
);

    logic [ENTRIES-1:0] match_v;
    logic [VA_W-1:0]    pa_v   [ENTRIES];
    logic [AP_W-1:0]    perm_v [ENTRIES];
    logic [ENTRIES-1:0] sel_oh;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        utlb_match i_match (
            .ent   (ents[g]),
            .va    (va),
            .match (match_v[g]),
            .pa    (pa_v[g]),
            .perm  (perm_v[g])
        );
    end

    // Lowest index wins: scan downward so the last write is the lowest match.
    always_comb begin
        hit    = 1'b0;
        pa     = '0;
        perm   = '0;
        sel_oh = '0;
        for (int k = ENTRIES - 1; k >= 0; k--) begin
            if (match_v[k]) begin
                sel_oh    = '0;
                sel_oh[k] = 1'b1;
                hit       = 1'b1;
                pa        = pa_v[k];
                perm      = perm_v[k];
            end
        end
    end

    a_r5_lowest_match: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((match_v & (sel_oh - 1'b1)) == '0));

    a_r5_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_oh) && (hit == (|match_v)));

endmodule

// File: rtl/utlb_victim.sv
`timescale 1ns/1ps
module utlb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int BASE_W = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BASE_W-1:0] base,
    input  logic [IDX_W-1:0]  ptr,
    output logic              can_fill,
    output logic [IDX_W-1:0]  victim,
    output logic [IDX_W-1:0]  ptr_next
);

    localparam logic [BASE_W-1:0] FULL = BASE_W'(ENTRIES);
    localparam logic [IDX_W-1:0]  LAST = IDX_W'(ENTRIES - 1);

    logic [BASE_W-1:0] ptr_ext;
    logic [BASE_W-1:0] vic_ext;

    always_comb begin
        ptr_ext  = BASE_W'(ptr);
        can_fill = (base < FULL);
        vic_ext  = (ptr_ext < base) ? base : ptr_ext;
        victim   = vic_ext[IDX_W-1:0];
        ptr_next = (victim == LAST) ? base[IDX_W-1:0] : victim + 1'b1;
    end

    a_r6_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        can_fill |-> (BASE_W'(victim) >= base));

    a_r6_next_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        can_fill |-> (BASE_W'(ptr_next) >= base));

endmodule

// File: rtl/utlb_lockdown.sv
`timescale 1ns/1ps
module utlb_lockdown
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int BASE_W = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       ilk_va,
    output logic              ilk_hit,
    output logic [31:0]       ilk_pa,
    output logic [1:0]        ilk_perm,
    input  logic [31:0]       dlk_va,
    output logic              dlk_hit,
    output logic [31:0]       dlk_pa,
    output logic [1:0]        dlk_perm,
    input  logic              fill_valid,
    input  logic [31:0]       fill_va,
    input  logic [31:0]       fill_pa,
    input  logic [1:0]        fill_size,
    input  logic [7:0]        fill_perm,
    input  logic [1:0]        mnt_op,
    input  logic [31:0]       mnt_va,
    input  logic [BASE_W-1:0] mnt_base
);

    localparam logic [BASE_W-1:0] FULL = BASE_W'(ENTRIES);

    typedef struct packed {
        tlb_entry_t [ENTRIES-1:0] ent;
        logic [BASE_W-1:0]        base;
        logic [IDX_W-1:0]         ptr;
    } state_t;

    state_t st_q, st_d;

    mnt_op_e          op;
    pg_size_e         fsz;
    logic             can_fill;
    logic [IDX_W-1:0] victim;
    logic [IDX_W-1:0] ptr_next;
    logic             fill_go;

    assign op  = mnt_op_e'(mnt_op);
    assign fsz = pg_size_e'(fill_size);

    utlb_victim #(.ENTRIES(ENTRIES)) i_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .base     (st_q.base),
        .ptr      (st_q.ptr),
        .can_fill (can_fill),
        .victim   (victim),
        .ptr_next (ptr_next)
    );

    // Instruction-side and data-side ports share the one array.
    utlb_lookup #(.ENTRIES(ENTRIES)) i_lk_instr (
        .clk   (clk),
        .rst_n (rst_n),
        .ents  (st_q.ent),
        .va    (ilk_va),
        .hit   (ilk_hit),
        .pa    (ilk_pa),
        .perm  (ilk_perm)
    );

    utlb_lookup #(.ENTRIES(ENTRIES)) i_lk_data (
        .clk   (clk),
        .rst_n (rst_n),
        .ents  (st_q.ent),
        .va    (dlk_va),
        .hit   (dlk_hit),
        .pa    (dlk_pa),
        .perm  (dlk_perm)
    );

    always_comb begin
        st_d    = st_q;
        fill_go = 1'b0;
        unique case (op)
            MNT_INV_ALL: begin
                for (int k = 0; k < ENTRIES; k++) begin
                    st_d.ent[k].valid = 1'b0;
                end
            end
            MNT_INV_VA: begin
                for (int k = 0; k < ENTRIES; k++) begin
                    if (entry_hits(st_q.ent[k], mnt_va)) begin
                        st_d.ent[k].valid = 1'b0;
                    end
                end
            end
            MNT_SET_LOCK: begin
                st_d.base = (mnt_base > FULL) ? FULL : mnt_base;
            end
            default: begin
                fill_go = fill_valid && (fsz != PG_RSVD) && can_fill;
            end
        endcase
        if (fill_go) begin
            st_d.ent[victim].valid = 1'b1;
            st_d.ent[victim].size  = fsz;
            st_d.ent[victim].vtag  = fill_va[VA_W-1:SMALL_SH];
            st_d.ent[victim].ptag  = fill_pa[VA_W-1:SMALL_SH];
            st_d.ent[victim].ap    = fill_perm;
            st_d.ptr               = ptr_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    a_r8_base_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.base <= FULL);

    a_r9_inv_all_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (op == MNT_INV_ALL) |=> (!ilk_hit && !dlk_hit));

    a_r11_maint_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (op != MNT_NONE) |=> $stable(st_q.ptr));

    a_r12_rsvd_size_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fsz == PG_RSVD) |=> $stable(st_q.ptr));

    for (genvar g = 0; g < ENTRIES; g++) begin : g_lockchk
        a_r7_locked_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (fill_valid && op == MNT_NONE && BASE_W'(g) < st_q.base) |=> $stable(st_q.ent[g]));
    end

endmodule

// File: tb/test_utlb_lockdown.sv
`timescale 1ns/1ps
module test_utlb_lockdown;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ilk_va = '0, dlk_va = '0;
    logic        ilk_hit, dlk_hit;
    logic [31:0] ilk_pa, dlk_pa;
    logic [1:0]  ilk_perm, dlk_perm;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_va = '0, fill_pa = '0;
    logic [1:0]  fill_size = '0;
    logic [7:0]  fill_perm = '0;
    logic [1:0]  mnt_op = '0;
    logic [31:0] mnt_va = '0;
    logic [4:0]  mnt_base = '0;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    utlb_lockdown i_utlb_lockdown (
        .clk(clk), .rst_n(rst_n),
        .ilk_va(ilk_va), .ilk_hit(ilk_hit), .ilk_pa(ilk_pa), .ilk_perm(ilk_perm),
        .dlk_va(dlk_va), .dlk_hit(dlk_hit), .dlk_pa(dlk_pa), .dlk_perm(dlk_perm),
        .fill_valid(fill_valid), .fill_va(fill_va), .fill_pa(fill_pa),
        .fill_size(fill_size), .fill_perm(fill_perm),
        .mnt_op(mnt_op), .mnt_va(mnt_va), .mnt_base(mnt_base)
    );

    // Behavioural reference model of the requirements.
    bit          m_v  [16];
    logic [1:0]  m_sz [16];
    logic [19:0] m_vt [16];
    logic [19:0] m_pt [16];
    logic [7:0]  m_ap [16];
    int          m_base = 0;
    int          m_ptr = 0;

    function automatic bit mdl_match(int k, logic [31:0] va);
        if (!m_v[k]) return 1'b0;
        case (m_sz[k])
            2'd0:    return m_vt[k] == va[31:12];
            2'd1:    return m_vt[k][19:4] == va[31:16];
            2'd2:    return m_vt[k][19:8] == va[31:20];
            default: return 1'b0;
        endcase
    endfunction

    task automatic mdl_look(input logic [31:0] va, output bit h,
                            output logic [31:0] pa, output logic [1:0] ap);
        int q;
        h = 0; pa = '0; ap = '0;
        for (int k = 0; k < 16; k++) begin
            if (!h && mdl_match(k, va)) begin
                h = 1;
                case (m_sz[k])
                    2'd0: begin pa = {m_pt[k], va[11:0]}; q = int'(va[11:10]); end
                    2'd1: begin pa = {m_pt[k][19:4], va[15:0]}; q = int'(va[15:14]); end
                    default: begin pa = {m_pt[k][19:8], va[19:0]}; q = 0; end
                endcase
                ap = m_ap[k][2*q +: 2];
            end
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 16; k++) m_v[k] = 0;
            m_base = 0;
            m_ptr  = 0;
        end else if (mnt_op == 2'd1) begin
            for (int k = 0; k < 16; k++) m_v[k] = 0;
        end else if (mnt_op == 2'd2) begin
            bit kill [16];
            for (int k = 0; k < 16; k++) kill[k] = mdl_match(k, mnt_va);
            for (int k = 0; k < 16; k++) if (kill[k]) m_v[k] = 0;
        end else if (mnt_op == 2'd3) begin
            m_base = (int'(mnt_base) > 16) ? 16 : int'(mnt_base);
        end else if (fill_valid && fill_size != 2'd3 && m_base < 16) begin
            int vic;
            vic = (m_ptr < m_base) ? m_base : m_ptr;
            m_v[vic]  = 1;
            m_sz[vic] = fill_size;
            m_vt[vic] = fill_va[31:12];
            m_pt[vic] = fill_pa[31:12];
            m_ap[vic] = fill_perm;
            m_ptr = (vic == 15) ? m_base : vic + 1;
        end
    end

    task automatic chk_port(string nm, bit ah, logic [31:0] apa, logic [1:0] aap, logic [31:0] va);
        bit eh; logic [31:0] epa; logic [1:0] eap;
        mdl_look(va, eh, epa, eap);
        checks++;
        if (ah !== eh || apa !== epa || aap !== eap) begin
            errors++;
            $display("FAIL %s %s va=%h: hit/pa/perm=%0b/%h/%0d expected %0b/%h/%0d",
                     cur_req, nm, va, ah, apa, aap, eh, epa, eap);
        end
    endtask

    // Compare both ports every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (!done) begin
            chk_port("instr", ilk_hit, ilk_pa, ilk_perm, ilk_va);
            chk_port("data",  dlk_hit, dlk_pa, dlk_perm, dlk_va);
        end
    end

    task automatic clr;
        fill_valid = 0; mnt_op = 2'd0;
    endtask

    task automatic do_fill(logic [31:0] va, logic [31:0] pa, logic [1:0] sz, logic [7:0] ap);
        @(posedge clk); #1; clr();
        fill_valid = 1; fill_va = va; fill_pa = pa; fill_size = sz; fill_perm = ap;
    endtask

    task automatic do_mnt(logic [1:0] op, logic [31:0] va, logic [4:0] b);
        @(posedge clk); #1; clr();
        mnt_op = op; mnt_va = va; mnt_base = b;
    endtask

    task automatic do_look(logic [31:0] iv, logic [31:0] dv);
        @(posedge clk); #1; clr();
        ilk_va = iv; dlk_va = dv;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state, all lookups miss
        cur_req = "R1";
        ilk_va = 32'h1234_5678; dlk_va = 32'h0000_0000;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        do_look(32'hFFFF_F000, 32'h0010_0000);
        do_look(32'h0000_1000, 32'h8000_0000);

        // R2 R3 R4: small page, all quarters, both ports at once
        cur_req = "R2/R3/R4 small";
        do_fill(32'h1234_5000, 32'hABCD_E000, 2'd0, 8'b11_10_01_00);
        do_look(32'h1234_5000, 32'h1234_5400);
        do_look(32'h1234_5ABC, 32'h1234_5FFF);
        do_look(32'h1234_6000, 32'h1234_4FFF);

        cur_req = "R2/R3 large";
        do_fill(32'h4001_0000, 32'h8765_0000, 2'd1, 8'b00_01_10_11);
        do_look(32'h4001_0000, 32'h4001_4321);
        do_look(32'h4001_8765, 32'h4001_C000);
        do_look(32'h4002_0000, 32'h4000_FFFF);

        cur_req = "R2/R3 section";
        do_fill(32'h7F03_4000, 32'h3A1F_F000, 2'd2, 8'b01_01_01_10);
        do_look(32'h7F00_0000, 32'h7FFF_FFFF);
        do_look(32'h7F0C_C00C, 32'h8000_0000);

        // R5: duplicate mapping in a higher slot is shadowed
        cur_req = "R5";
        do_fill(32'h1234_5000, 32'h5555_5000, 2'd0, 8'hFF);
        do_look(32'h1234_5123, 32'h1234_5C00);

        // R10: invalidate by address removes both duplicates only
        cur_req = "R10";
        do_mnt(2'd2, 32'h1234_5678, 5'd0);
        do_look(32'h1234_5000, 32'h4001_0000);
        do_look(32'h7F01_0000, 32'h1234_5FFF);
        do_mnt(2'd2, 32'h7F0F_0000, 5'd0);
        do_look(32'h7F01_0000, 32'h4001_C000);

        // R6 R7: fill everything, lock six, then overfill
        cur_req = "R6/R7";
        do_mnt(2'd1, 32'h0, 5'd0);
        for (int j = 0; j < 16; j++)
            do_fill(32'h0010_0000 + j * 32'h1000, 32'h0900_0000 + j * 32'h1000, 2'd0, 8'(j));
        do_mnt(2'd3, 32'h0, 5'd6);
        for (int j = 16; j < 36; j++)
            do_fill(32'h0010_0000 + j * 32'h1000, 32'h0900_0000 + j * 32'h1000, 2'd0, 8'(j));
        for (int j = 0; j < 36; j++)
            do_look(32'h0010_0000 + j * 32'h1000, 32'h0010_0C00 + j * 32'h1000);

        // R9: invalidate all clears locked entries too
        cur_req = "R9";
        do_mnt(2'd1, 32'h0, 5'd0);
        for (int j = 0; j < 36; j += 5)
            do_look(32'h0010_0000 + j * 32'h1000, 32'h0010_0000 + (j + 1) * 32'h1000);

        // R8: saturated base discards refills
        cur_req = "R8";
        do_mnt(2'd3, 32'h0, 5'd20);
        do_fill(32'h2000_0000, 32'h3000_0000, 2'd0, 8'h55);
        do_look(32'h2000_0000, 32'h2000_0800);
        do_mnt(2'd3, 32'h0, 5'd0);
        do_fill(32'h2000_0000, 32'h3000_0000, 2'd0, 8'h55);
        do_look(32'h2000_0000, 32'h2000_0800);

        // R11: refill alongside maintenance is dropped
        cur_req = "R11";
        @(posedge clk); #1; clr();
        fill_valid = 1; fill_va = 32'h2100_0000; fill_pa = 32'h3100_0000;
        fill_size = 2'd0; fill_perm = 8'hAA; mnt_op = 2'd3; mnt_base = 5'd1;
        do_look(32'h2100_0000, 32'h2000_0000);

        // R12: reserved size code ignored, next fill lands per pointer
        cur_req = "R12";
        do_fill(32'h2200_0000, 32'h3200_0000, 2'd3, 8'hFF);
        do_look(32'h2200_0000, 32'h2200_0FFF);
        do_fill(32'h2300_0000, 32'h3300_0000, 2'd1, 8'h1B);
        do_look(32'h2300_4000, 32'h2200_0000);

        // Mixed random traffic over a small address pool
        cur_req = "R2/R5/R6/R10 mixed";
        for (int n = 0; n < 600; n++) begin
            logic [31:0] base_va;
            int r;
            r = int'($urandom_range(0, 99));
            base_va = {4'h5, 4'($urandom_range(0, 3)), 8'h00, 4'($urandom_range(0, 3)), 12'h000};
            if (r < 30)
                do_fill(base_va, $urandom, 2'($urandom_range(0, 3)), 8'($urandom));
            else if (r < 34)
                do_mnt(2'd2, base_va | 32'($urandom_range(0, 4095)), 5'd0);
            else if (r < 36)
                do_mnt(2'd3, 32'h0, 5'($urandom_range(0, 17)));
            else if (r < 37)
                do_mnt(2'd1, 32'h0, 5'd0);
            else
                do_look(base_va | 32'($urandom_range(0, 65535)),
                        {4'h5, 4'($urandom_range(0, 3)), 24'($urandom)});
        end
        do_look(32'h0, 32'h0);
        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule